// File: doc/BRIEF.md
# Coarse-Grained Thread Switch Controller

This block picks which of a small set of hardware thread contexts owns a single-issue pipeline. The chosen thread runs with no interruption until it reports a long-latency miss, such as a last-level cache miss that has to go off-chip. The controller then marks that thread as waiting and passes the pipeline to another context. Each context keeps its own program counter and private registers in the pipeline, so a switch needs no save or restore through memory. Only the thread identifier changes.

Short pipeline stalls never cause a switch. While one is present the running thread holds fetch and waits. A switch flushes the pipeline and leaves a refill bubble while the new thread's instructions move through empty stages. The bubble length comes from an input, and it is sampled at the moment of the switch. When no context is ready the controller goes idle. It resumes on the first miss resolution that arrives.

Top module: `cg_thread_switch`

## Requirements
- R1: After reset the active thread is 0, every context is ready, fetch_valid is 1 and flush is 0.
- R2: While no long miss is taken, active_id does not change.
- R3: A short stall never changes active_id and never raises flush. fetch_valid is 0 in every running cycle where short_stall is 1 and returns to 1 once short_stall drops.
- R4: A long miss taken while running selects the next ready context in rotating order active+1, active+2, ... modulo NUM_CTX, excluding the missing thread. The new id appears on active_id in the cycle after the miss.
- R5: The thread that takes the miss becomes waiting and is skipped by every later selection until a one-cycle pulse on its bit of resolve arrives.
- R6: flush is 1 for exactly one cycle, the first cycle after a switch, and is 0 at all other times.
- R7: After a switch fetch_valid is 0 for max(refill_depth, 1) cycles, starting with the flush cycle. refill_depth is the value present in the cycle the switch is taken.
- R8: A long miss with no other ready context makes the controller idle. In that state fetch_valid stays 0, flush stays 0 and active_id holds the last thread.
- R9: An idle controller switches to the thread whose resolve bit rises first, with a flush and a refill bubble. If several bits rise together, the pick follows the rotating order from active+1.
- R10: A long miss that arrives while refilling or idle is ignored. It has no effect on active_id, on the bubble length or on the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_miss | input | 1 | Running thread reports a long-latency miss |
| short_stall | input | 1 | Short pipeline stall; running thread holds fetch |
| resolve | input | NUM_CTX | Per-context miss-resolved pulse |
| refill_depth | input | REFILL_W | Refill bubble length in cycles |
| active_id | output | $clog2(NUM_CTX) | Thread that owns the pipeline |
| flush | output | 1 | One-cycle pipeline flush on a switch |
| fetch_valid | output | 1 | High when the active thread may fetch |

## Verification
The bench builds the controller with NUM_CTX = 3 and REFILL_W = 3. Three contexts is not a power of two, so the rotating pick has to wrap by subtraction instead of by bit truncation, and the wrap from context 2 back to 0 comes up many times. The 3-bit refill field allows a full sweep of every bubble length from 0 to 7, which includes the zero case that still produces one cycle. With three threads it is also cheap to drive every context into the waiting state, which reaches the idle path and the case of several resolutions arriving together.

// File: rtl/cgts_pkg.sv
package cgts_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_REFILL = 2'd1,
        ST_IDLE   = 2'd2
    } ctl_state_e;

    // (base + off) modulo n, for base < n and off <= n
    function automatic int unsigned wrap_idx(int unsigned base, int unsigned off, int unsigned n);
        int unsigned s;
        s = base + off;
        return (s >= n) ? s - n : s;
    endfunction

endpackage

// File: rtl/cgts_rr_pick.sv
module cgts_rr_pick #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input  logic [N-1:0]     cand,
    input  logic [TID_W-1:0] base,
    output logic             found,
    output logic [TID_W-1:0] pick
);
    import cgts_pkg::*;

    logic [N-1:0] rot;
    int unsigned  first;

    // rot[k-1] is the candidate k steps after base
    for (genvar k = 1; k <= N; k++) begin : g_rot
        assign rot[k-1] = cand[TID_W'(wrap_idx(32'(base), k, N))];
    end

    always_comb begin
        found = 1'b0;
        first = 0;
        for (int k = N - 1; k >= 0; k--) begin
            if (rot[k]) begin
                found = 1'b1;
                first = k;
            end
        end
        pick = TID_W'(wrap_idx(32'(base), first + 1, N));
    end

endmodule

// File: rtl/cgts_ready_track.sv
module cgts_ready_track #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     resolve,
    input  logic             clr_en,
    input  logic [TID_W-1:0] clr_id,
    output logic [N-1:0]     ready
);
    logic [N-1:0] ready_d;

    always_comb begin
        ready_d = ready | resolve;
        if (clr_en) ready_d[clr_id] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ready <= '1;
        else     ready <= ready_d;
    end

endmodule

// File: rtl/cgts_refill_timer.sv
module cgts_refill_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] depth,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                          cnt_q <= '0;
        else if (load)                    cnt_q <= depth;
        else if (dec && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q <= W'(1));

endmodule

// File: rtl/cg_thread_switch.sv
module cg_thread_switch #(
    parameter int NUM_CTX  = 4,
    parameter int REFILL_W = 4,
    localparam int TID_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                long_miss,
    input  logic                short_stall,
    input  logic [NUM_CTX-1:0]  resolve,
    input  logic [REFILL_W-1:0] refill_depth,
    output logic [TID_W-1:0]    active_id,
    output logic                flush,
    output logic                fetch_valid
);
    import cgts_pkg::*;

    ctl_state_e         state_q, state_d;
    logic [TID_W-1:0]   active_q;
    logic [NUM_CTX-1:0] ready_q;
    logic [NUM_CTX-1:0] cand;
    logic               running, take_miss, found, do_switch, refill_last;
    logic [TID_W-1:0]   pick;
    logic               flush_q;

    assign running   = (state_q == ST_RUN);
    assign take_miss = running & long_miss;

    // candidates: ready now or resolving this cycle, minus a thread that is missing
    for (genvar i = 0; i < NUM_CTX; i++) begin : g_cand
        assign cand[i] = (ready_q[i] | resolve[i]) & ~(take_miss && active_q == TID_W'(i));
    end

    cgts_ready_track #(.N(NUM_CTX), .TID_W(TID_W)) u_ready (
        .clk(clk), .rst(rst), .resolve(resolve),
        .clr_en(take_miss), .clr_id(active_q), .ready(ready_q)
    );

    cgts_rr_pick #(.N(NUM_CTX), .TID_W(TID_W)) u_pick (
        .cand(cand), .base(active_q), .found(found), .pick(pick)
    );

    assign do_switch = found & (take_miss | (state_q == ST_IDLE));

    cgts_refill_timer #(.W(REFILL_W)) u_timer (
        .clk(clk), .rst(rst), .load(do_switch),
        .dec(state_q == ST_REFILL), .depth(refill_depth), .last(refill_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (take_miss) state_d = found ? ST_REFILL : ST_IDLE;
            ST_REFILL: if (refill_last) state_d = ST_RUN;
            ST_IDLE:   if (found) state_d = ST_REFILL;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            active_q <= '0;
            flush_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            flush_q  <= do_switch;
            if (do_switch) active_q <= pick;
        end
    end

    assign active_id   = active_q;
    assign flush       = flush_q;
    assign fetch_valid = running & ~short_stall;

endmodule

// File: rtl/cgts_checker.sv
module cgts_checker #(
    parameter int N     = 4,
    parameter int TID_W = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 long_miss,
    input logic                 short_stall,
    input logic [TID_W-1:0]     active_id,
    input logic                 flush,
    input logic                 fetch_valid,
    input cgts_pkg::ctl_state_e state_q
);
    import cgts_pkg::*;

    // R6: a flush never lasts two cycles
    p_flush_single_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> !flush);

    // R7: the flush cycle is part of the refill bubble
    p_flush_no_fetch_r7: assert property (@(posedge clk) disable iff (rst)
        flush |-> !fetch_valid);

    // R2: without a miss while fetching, the thread stays
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !long_miss) |=> $stable(active_id));

    // R3: a stall alone never flushes or switches
    p_stall_no_switch_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && short_stall && !long_miss) |=> (!flush && $stable(active_id)));

    // R4: a taken miss always leaves the run state
    p_miss_leaves_run_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && long_miss) |=> !fetch_valid);

    // R8: idle never flushes and keeps the id
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (!flush && !fetch_valid));

    // R10: a miss outside running does not reopen fetch at once from idle
    p_idle_miss_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && long_miss) |=> !fetch_valid);

    // R4: id always names an existing context
    p_id_range_r4: assert property (@(posedge clk) disable iff (rst)
        32'(active_id) < N);

endmodule

bind cg_thread_switch cgts_checker #(.N(NUM_CTX), .TID_W(TID_W)) u_chk (
    .clk(clk), .rst(rst), .long_miss(long_miss), .short_stall(short_stall),
    .active_id(active_id), .flush(flush), .fetch_valid(fetch_valid), .state_q(state_q)
);

// File: tb/tb_cg_thread_switch.sv
module tb_cg_thread_switch;
    localparam int NC = 3;
    localparam int RW = 3;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          long_miss = 1'b0;
    logic          short_stall = 1'b0;
    logic [NC-1:0] resolve = '0;
    logic [RW-1:0] refill_depth = '0;
    logic [TW-1:0] active_id;
    logic          flush, fetch_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int cur = 0;

    always #4 clk = ~clk;

    cg_thread_switch #(.NUM_CTX(NC), .REFILL_W(RW)) dut (
        .clk(clk), .rst(rst), .long_miss(long_miss), .short_stall(short_stall),
        .resolve(resolve), .refill_depth(refill_depth),
        .active_id(active_id), .flush(flush), .fetch_valid(fetch_valid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // counts bubble samples, starting on the flush sample
    task automatic measure(input int depth, input int poke_at);
        int n;
        n = 0;
        while (!fetch_valid && n < 20) begin
            n++;
            if (n == poke_at) long_miss = 1'b1;
            @(negedge clk);
            long_miss = 1'b0;
            if (!fetch_valid) check(flush == 1'b0, "R6 flush after first cycle", int'(flush), 0);
        end
        check(n == ((depth == 0) ? 1 : depth), "R7 bubble length", n, (depth == 0) ? 1 : depth);
    endtask

    task automatic miss_switch(input int exp, input int depth, input int poke_at);
        refill_depth = RW'(depth);
        long_miss = 1'b1;
        @(negedge clk);
        long_miss = 1'b0;
        check(int'(active_id) == exp, "R4 next thread", int'(active_id), exp);
        check(flush == 1'b1, "R6 flush on switch", int'(flush), 1);
        measure(depth, poke_at);
        check(int'(active_id) == exp, "R10 id after bubble", int'(active_id), exp);
        cur = exp;
    endtask

    task automatic pulse_resolve(input logic [NC-1:0] v);
        resolve = v;
        @(negedge clk);
        resolve = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(active_id == 0, "R1 reset id", int'(active_id), 0);
        check(fetch_valid == 1'b1, "R1 reset fetch", int'(fetch_valid), 1);
        check(flush == 1'b0, "R1 reset flush", int'(flush), 0);

        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(active_id == 0, "R2 hold", int'(active_id), 0);
        end

        short_stall = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1;
            check(fetch_valid == 1'b0, "R3 stall fetch", int'(fetch_valid), 0);
            @(negedge clk);
            check(active_id == 0 && flush == 1'b0, "R3 stall no switch", int'(active_id), 0);
        end
        short_stall = 1'b0;
        #1;
        check(fetch_valid == 1'b1, "R3 stall release", int'(fetch_valid), 1);

        // sweep every refill depth; missing thread resolved afterwards
        for (int d = 0; d < 8; d++) begin
            int prev;
            prev = cur;
            miss_switch((cur + 1) % NC, d, 0);
            pulse_resolve(NC'(1) << prev);
        end

        // R5 skipping: thread 2 waits
        miss_switch((cur + 1) % NC, 2, 0);     // 2 -> 0, 2 waits
        miss_switch(1, 1, 0);                 // 0 -> 1, 0 waits
        pulse_resolve(3'b001);                // 0 ready again
        miss_switch(0, 2, 0);                 // R5: 2 skipped, 1 -> 0
        check(active_id == 0, "R5 waiting thread skipped", int'(active_id), 0);

        // R8: all waiting
        long_miss = 1'b1;
        @(negedge clk);
        long_miss = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(fetch_valid == 1'b0 && flush == 1'b0, "R8 idle quiet", int'(fetch_valid), 0);
            check(active_id == 0, "R8 idle id held", int'(active_id), 0);
            if (i == 1) long_miss = 1'b1;
            @(negedge clk);
            long_miss = 1'b0;
        end
        check(fetch_valid == 1'b0 && flush == 1'b0, "R10 miss in idle ignored", int'(fetch_valid), 0);

        // R9: simultaneous resolves of 1 and 2 from active 0 -> 1
        refill_depth = RW'(3);
        resolve = 3'b110;
        @(negedge clk);
        resolve = '0;
        check(active_id == 1, "R9 resume pick", int'(active_id), 1);
        check(flush == 1'b1, "R9 resume flush", int'(flush), 1);
        measure(3, 0);

        // R10: miss during refill ignored (1 -> 2, poke in bubble)
        miss_switch(2, 5, 2);
        check(fetch_valid == 1'b1, "R10 running after bubble", int'(fetch_valid), 1);

        // R9: single resolve from idle (waiting: 0,1 after next miss)
        long_miss = 1'b1;
        @(negedge clk);
        long_miss = 1'b0;
        check(fetch_valid == 1'b0 && flush == 1'b0, "R8 idle again", int'(flush), 0);
        pulse_resolve(3'b001);
        check(active_id == 0, "R9 first resolved", int'(active_id), 0);
        check(flush == 1'b1, "R9 flush", int'(flush), 1);
        measure(5, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule